// File: doc/BRIEF.md
# Latched Event Status Register

This block keeps a small set of sticky event flags for an instrument's remote status reporting. Each condition input is synchronized to the clock. A flag is set only when its condition goes from 0 to 1, so a condition that stays high does not set the flag again after a read has cleared it. The host can read all the flags at once, which clears every flag. It can also read one selected flag, which clears only that flag. A clear-all strobe resets every flag.

A host-writable enable register masks the flags. The masked result is reduced by OR to one summary bit, which a higher-level status byte collects. The parameter `ACTIVE_MASK` selects which bit positions exist. The default `8'h0F` gives four events in bits 0 to 3, for example stopped, arrived, unlocked and locked for a reference clock. A setting of `8'h07` gives three overload flags. Bits outside the mask always read 0.

Top module: `event_status_reg`

## Requirements
- R1: After reset, `flags_o`, `rdata_o` and `en_rdata_o` are all 0 and `summary_o` is 0.
- R2: A 0-to-1 change on `cond_i[i]` sets flag i. The flag is visible on `flags_o` and `rdata_o` after the third rising clock edge that follows the change: two synchronizer edges, then the flag edge.
- R3: A condition that stays at 1 never sets its flag a second time. Once the flag is cleared, it stays 0 until the condition goes to 0 and then back to 1.
- R4: While `rd_all_i` is 1, `rdata_o` equals the flag vector. At that clock edge every flag is cleared.
- R5: While `rd_bit_i` is 1 and `rd_all_i` is 0, `rdata_o` is `{0..., flag[rd_sel_i]}`, with the flag in bit 0. At that edge only flag `rd_sel_i` is cleared, and the other flags keep their values.
- R6: A 1 on `clr_all_i` clears every flag at the next edge.
- R7: If a new rising edge of a condition and a clear of the same flag (by read or by clear-all) fall in the same cycle, the flag ends up at 1.
- R8: When `en_wr_i` is 1, `en_wdata_i` is stored in the enable register at the edge. The value appears on `en_rdata_o` from the next cycle. The enable register is 0 after reset.
- R9: `summary_o` is 1 exactly when `(flags & enable) != 0`. It is combinational, so it follows a flag or enable change in the same cycle.
- R10: Flag bits whose `ACTIVE_MASK` bit is 0 always read 0, even when their condition has rising edges. The default mask is `8'h0F`.
- R11: When `rd_all_i` and `rd_bit_i` are both 1, the whole-register read takes effect: the full flag vector is returned and every flag is cleared.
- R12: With no read strobe active, `rdata_o` equals the flag vector.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cond_i | input | WIDTH | Raw condition levels, asynchronous |
| rd_all_i | input | 1 | Whole-register read strobe; clears all flags |
| rd_bit_i | input | 1 | Single-flag read strobe |
| rd_sel_i | input | SEL_W | Index of the flag for a single-flag read |
| clr_all_i | input | 1 | Clear-all command strobe |
| en_wr_i | input | 1 | Enable register write strobe |
| en_wdata_i | input | WIDTH | Enable register write data |
| rdata_o | output | WIDTH | Read data (combinational) |
| flags_o | output | WIDTH | Current flag vector |
| en_rdata_o | output | WIDTH | Enable register readback |
| summary_o | output | 1 | OR of flags ANDed with the enable register |

## Verification
The results of this block fall due at three different times. A condition edge reaches a flag after exactly three clock edges. Clears and enable writes take effect one edge after their strobe. `rdata_o` and `summary_o` follow their inputs in the same cycle. A behavioural model in the bench keeps a three-slot delay line for the conditions and updates its flag and enable state at each rising edge. The outputs are compared with the model at every falling edge, after all inputs and registered state have settled. Directed checks sample R2 at exactly the second and third edges after a condition rises, so a latency that is off by one edge is caught.

// File: rtl/esr_pkg.sv
package esr_pkg;

  typedef enum logic [1:0] {
    RD_NONE   = 2'd0,
    RD_WHOLE  = 2'd1,
    RD_SINGLE = 2'd2
  } rd_kind_e;

  // whole-register read outranks single-flag read (R11)
  function automatic rd_kind_e decode_read(input logic whole, input logic single);
    if (whole) return RD_WHOLE;
    if (single) return RD_SINGLE;
    return RD_NONE;
  endfunction

endpackage

// File: rtl/esr_edge_sync.sv
module esr_edge_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] cond_i,
  output logic [WIDTH-1:0] rise_o
);

  logic [WIDTH-1:0] sync_w;
  logic [WIDTH-1:0] prev_w;

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES:0] chain_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-1:0], cond_i[b]};
    end
    assign sync_w[b] = chain_q[STAGES-1];
    assign prev_w[b] = chain_q[STAGES];
  end

  assign rise_o = sync_w & ~prev_w;

  // a held condition gives a single-cycle pulse only (R3)
  p_rise_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_o & $past(rise_o)) == '0);

endmodule

// File: rtl/esr_flag_bank.sv
module esr_flag_bank
  import esr_pkg::*;
#(
  parameter int unsigned     WIDTH       = 8,
  parameter logic [WIDTH-1:0] ACTIVE_MASK = 8'h0F,
  localparam int unsigned    SEL_W       = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] set_i,
  input  rd_kind_e         rd_kind_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             clr_all_i,
  output logic [WIDTH-1:0] flags_o
);

  logic [WIDTH-1:0] flags_q;
  logic [WIDTH-1:0] clr_w;
  logic [WIDTH-1:0] set_w;

  function automatic logic [WIDTH-1:0] clear_vector(input rd_kind_e k,
                                                    input logic [SEL_W-1:0] s,
                                                    input logic all);
    logic [WIDTH-1:0] v;
    v = '0;
    for (int i = 0; i < WIDTH; i++) begin
      if (all || k == RD_WHOLE) v[i] = 1'b1;
      else if (k == RD_SINGLE && s == SEL_W'(i)) v[i] = 1'b1;
    end
    return v;
  endfunction

  assign clr_w = clear_vector(rd_kind_i, sel_i, clr_all_i);
  assign set_w = set_i & ACTIVE_MASK;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= (flags_q & ~clr_w) | set_w;
  end

  assign flags_o = flags_q;

  // R7: a set is never lost, even against a clear
  p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(set_i & ACTIVE_MASK) & ~flags_q) == '0);

  // R6: clear-all with no edge empties the register
  p_clear_all_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_all_i && set_i == '0) |=> flags_q == '0);

  // R3: a flag rises only from an edge
  p_no_spurious_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_q & ~$past(flags_q) & ~$past(set_i)) == '0);

  // R10: unimplemented positions stay empty
  p_unused_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_q & ~ACTIVE_MASK) == '0);

endmodule

// File: rtl/esr_enable.sv
module esr_enable #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] en_o
);

  logic [WIDTH-1:0] en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    en_q <= '0;
    else if (wr_i) en_q <= wdata_i;
  end

  assign en_o = en_q;

  p_en_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> en_q == $past(wdata_i));

  p_en_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> $stable(en_q));

endmodule

// File: rtl/event_status_reg.sv
module event_status_reg
  import esr_pkg::*;
#(
  parameter int unsigned      WIDTH       = 8,
  parameter int unsigned      SYNC_STAGES = 2,
  parameter logic [WIDTH-1:0] ACTIVE_MASK = 8'h0F,
  localparam int unsigned     SEL_W       = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] cond_i,
  input  logic             rd_all_i,
  input  logic             rd_bit_i,
  input  logic [SEL_W-1:0] rd_sel_i,
  input  logic             clr_all_i,
  input  logic             en_wr_i,
  input  logic [WIDTH-1:0] en_wdata_i,
  output logic [WIDTH-1:0] rdata_o,
  output logic [WIDTH-1:0] flags_o,
  output logic [WIDTH-1:0] en_rdata_o,
  output logic             summary_o
);

  logic [WIDTH-1:0] rise_w;
  logic [WIDTH-1:0] flags_w;
  logic [WIDTH-1:0] en_w;
  rd_kind_e         rd_kind_w;

  function automatic logic any_enabled(input logic [WIDTH-1:0] f,
                                       input logic [WIDTH-1:0] e);
    return |(f & e);
  endfunction

  function automatic logic [WIDTH-1:0] read_mux(input rd_kind_e k,
                                                input logic [WIDTH-1:0] f,
                                                input logic [SEL_W-1:0] s);
    logic [WIDTH-1:0] r;
    r = f;
    if (k == RD_SINGLE) begin
      r    = '0;
      r[0] = f[s];
    end
    return r;
  endfunction

  assign rd_kind_w = decode_read(rd_all_i, rd_bit_i);

  esr_edge_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .cond_i(cond_i), .rise_o(rise_w)
  );

  esr_flag_bank #(.WIDTH(WIDTH), .ACTIVE_MASK(ACTIVE_MASK)) u_flags (
    .clk(clk), .rst_n(rst_n), .set_i(rise_w), .rd_kind_i(rd_kind_w),
    .sel_i(rd_sel_i), .clr_all_i(clr_all_i), .flags_o(flags_w)
  );

  esr_enable #(.WIDTH(WIDTH)) u_en (
    .clk(clk), .rst_n(rst_n), .wr_i(en_wr_i), .wdata_i(en_wdata_i), .en_o(en_w)
  );

  assign rdata_o    = read_mux(rd_kind_w, flags_w, rd_sel_i);
  assign flags_o    = flags_w;
  assign en_rdata_o = en_w;
  assign summary_o  = any_enabled(flags_w, en_w);

  // R9: summary only with some flag present and some enable bit set
  p_summary_r9: assert property (@(posedge clk) disable iff (!rst_n)
    summary_o |-> (flags_w != '0 && en_w != '0));

  // R4 / R11: a whole read leaves nothing but fresh edges
  p_whole_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_all_i && !clr_all_i) |=> (flags_w & ~$past(rise_w)) == '0);

endmodule

// File: tb/sim_event_status_reg.sv
module sim_event_status_reg;
  localparam int W = 8;
  localparam logic [W-1:0] MASK = 8'h0F;

  logic clk = 0, rst_n = 0;
  logic [W-1:0] cond = '0, en_wdata = '0;
  logic rd_all = 0, rd_bit = 0, clr_all = 0, en_wr = 0;
  logic [2:0] rd_sel = '0;
  logic [W-1:0] rdata, flags, en_rd;
  logic summary;

  int tests = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  event_status_reg u0 (
    .clk(clk), .rst_n(rst_n), .cond_i(cond), .rd_all_i(rd_all), .rd_bit_i(rd_bit),
    .rd_sel_i(rd_sel), .clr_all_i(clr_all), .en_wr_i(en_wr), .en_wdata_i(en_wdata),
    .rdata_o(rdata), .flags_o(flags), .en_rdata_o(en_rd), .summary_o(summary)
  );

  // behavioural model
  int dly [3];
  logic [W-1:0] line [3];
  logic [W-1:0] m_flags = '0, m_en = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_flags = '0; m_en = '0;
      for (int k = 0; k < 3; k++) line[k] = '0;
    end else begin
      logic [W-1:0] edges, wipe;
      edges = line[1] & ~line[2] & MASK;
      wipe = '0;
      if (clr_all || rd_all) wipe = '1;
      else if (rd_bit) wipe[rd_sel] = 1'b1;
      m_flags = (m_flags & ~wipe) | edges;
      if (en_wr) m_en = en_wdata;
      line[2] = line[1]; line[1] = line[0]; line[0] = cond;
    end
  end

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [W-1:0] er;
      er = m_flags;
      if (!rd_all && rd_bit) er = {{(W-1){1'b0}}, m_flags[rd_sel]};
      check("R4/R5/R11/R12 rdata", rdata, er);
      check("R2 flags", flags, m_flags);
      check("R8 enable", en_rd, m_en);
      check("R9 summary", {7'b0, summary}, {7'b0, |(m_flags & m_en)});
    end
  end

  task automatic tick(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #2;
    end
  endtask

  task automatic strobe_all();  rd_all = 1; tick(1); rd_all = 0; endtask
  task automatic strobe_bit(int s); rd_bit = 1; rd_sel = 3'(s); tick(1); rd_bit = 0; endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    #500000;
    tests++; fails++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    tick(3);
    rst_n = 1;
    tick(1);
    // R1 reset state
    check("R1 rdata", rdata, '0);
    check("R1 enable", en_rd, '0);
    check("R1 summary", {7'b0, summary}, '0);

    // R2 latency: visible after the third edge, not the second
    cond = 8'h02; tick(2);
    check("R2 early", flags, 8'h00);
    tick(1);
    check("R2 set", flags, 8'h02);

    // R3: held condition stays cleared after a whole read (R4)
    strobe_all();
    check("R4 cleared", flags, 8'h00);
    tick(5);
    check("R3 held", flags, 8'h00);
    cond = 8'h00; tick(2); cond = 8'h02; tick(3);
    check("R3 re-edge", flags, 8'h02);

    // R5 single-bit read
    cond = 8'h0B; tick(4);
    check("R5 before", flags, 8'h0B);
    rd_bit = 1; rd_sel = 3'd3; #1;
    check("R5 data", rdata, 8'h01);
    tick(1); rd_bit = 0;
    check("R5 only bit3", flags, 8'h03);
    strobe_bit(2);
    check("R5 zero bit", flags, 8'h03);

    // R8/R9 enable and summary
    en_wdata = 8'h04; en_wr = 1; tick(1); en_wr = 0;
    check("R8 readback", en_rd, 8'h04);
    check("R9 masked off", {7'b0, summary}, '0);
    en_wdata = 8'h01; en_wr = 1; tick(1); en_wr = 0;
    check("R9 on", {7'b0, summary}, 8'h01);

    // R6 clear-all
    clr_all = 1; tick(1); clr_all = 0;
    check("R6 clear", flags, 8'h00);

    // R7 edge coincident with clears
    cond = 8'h00; tick(3);
    cond = 8'h01; tick(2);
    clr_all = 1; tick(1); clr_all = 0;
    check("R7 clr-all vs set", flags, 8'h01);
    cond = 8'h00; tick(3); cond = 8'h01; tick(2);
    strobe_bit(0);
    check("R7 bit read vs set", flags, 8'h01);

    // R10 unimplemented bits
    cond = 8'h00; tick(3); strobe_all();
    cond = 8'hF0; tick(4);
    check("R10 unused", rdata, 8'h00);

    // R11 both strobes
    cond = 8'h00; tick(3); cond = 8'h05; tick(4);
    rd_all = 1; rd_bit = 1; rd_sel = 3'd0; #1;
    check("R11 data", rdata, 8'h05);
    tick(1); rd_all = 0; rd_bit = 0;
    check("R11 cleared", flags, 8'h00);

    // mixed traffic against the model
    for (int i = 0; i < 300; i++) begin
      cond = 8'((i * 37) ^ (i >> 2));
      rd_all = (i % 11) == 3;
      rd_bit = (i % 5) == 1;
      rd_sel = 3'(i % 7);
      clr_all = (i % 23) == 9;
      en_wr = (i % 13) == 2;
      en_wdata = 8'(i * 29);
      tick(1);
    end
    rd_all = 0; rd_bit = 0; clr_all = 0; en_wr = 0;
    tick(2);
    finish_up();
  end
endmodule